// File: doc/BRIEF.md
# Carrier-Period FSK Bit Demodulator

This block recovers the data bits carried by a frequency-shift-keyed signal that a proximity tag sends back to a 125 kHz reader. The analog front end delivers a comparator bit whose rising edges arrive every 8 or 10 carrier cycles. The block derives the carrier from the system clock. It measures the gap between successive rising edges in whole carrier cycles and reports a 1 for a long gap and a 0 for a short gap.

Each rising edge is synchronised and turned into a one-clock strobe. A one-hot ring advances once per carrier cycle, and each strobe clears it. One tap of the ring, reached only after nine advances, is captured into the data register on the strobe, so the decided bit stays steady for the whole of the following gap. The ring stops at that tap instead of wrapping, so an overlong gap still reads as a long one.

Top module: `fsk_period_demod`

## Requirements
- R1: `carrier_out` is a square wave that changes level every 64 clocks, giving a period of 128 clocks. It is low during reset and for the first 64 clocks after reset.
- R2: Each low-to-high change of `comp_in` produces exactly one `edge_pulse`, one clock wide. It is high in the second clock after the change is first sampled. High-to-low changes of `comp_in` produce no pulse.
- R3: When two successive rising edges of `comp_in` are 10 carrier periods (1280 clocks) apart, `data_out` is 1 from the clock after the closing edge pulse.
- R4: When successive rising edges are 8 carrier periods (1024 clocks) apart, or fewer (such as 5), `data_out` is 0 from the clock after the closing edge pulse.
- R5: `data_out` changes only in the clock after an edge pulse. It holds its value through every gap, and it holds its value for any length of time while `comp_in` carries no rising edge.
- R6: Synchronous active-high `rst` drives `carrier_out`, `edge_pulse` and `data_out` low and places the ring at position 0.
- R7: A gap longer than 10 carrier periods (14 periods, or an idle stretch after reset) decodes as 1, because the ring holds at its last position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, nominally 16 MHz |
| rst | input | 1 | Synchronous active-high reset |
| comp_in | input | 1 | Raw comparator bit from the analog front end, asynchronous |
| carrier_out | output | 1 | Carrier square wave at clk/128 |
| edge_pulse | output | 1 | One-clock strobe for each rising edge of comp_in |
| data_out | output | 1 | Decided bit for the most recently closed gap |

## Verification
The assertions assume that `comp_in` stays at each level for well over three clocks. This keeps the synchroniser from ever producing two strobes closer together than one clock apart. The assertions also assume that reset is applied from the first clock, so the carrier gap counter starts in step with the divider. The stimulus drives `comp_in` only at falling clock edges, as square waves with equal high and low halves of at least 320 clocks each. Gaps of exactly 8, 10, 5 and 14 carrier periods stay clear of the 9-period boundary, where the decision would depend on the carrier phase.

// File: rtl/fsk_period_demod.sv
module fsk_period_demod #(
  parameter int DIV_HALF = 64,
  parameter int RING_LEN = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic comp_in,
  output logic carrier_out,
  output logic edge_pulse,
  output logic data_out
);
  localparam int DW  = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
  localparam int TAP = RING_LEN - 1;
  localparam logic [DW-1:0] DIV_LAST = DW'(DIV_HALF - 1);

  logic [DW-1:0]       div_cnt;
  logic                carrier_q;
  logic                tick;
  logic [2:0]          sync_q;
  logic [RING_LEN-1:0] ring;
  logic                bit_q;

  assign tick        = (div_cnt == DIV_LAST) && carrier_q;
  assign carrier_out = carrier_q;
  assign edge_pulse  = sync_q[1] & ~sync_q[2];
  assign data_out    = bit_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_cnt   <= '0;
      carrier_q <= 1'b0;
    end else if (div_cnt == DIV_LAST) begin
      div_cnt   <= '0;
      carrier_q <= ~carrier_q;
    end else begin
      div_cnt <= div_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '0;
    else     sync_q <= {sync_q[1:0], comp_in};
  end

  always_ff @(posedge clk) begin
    if (rst || edge_pulse)      ring <= RING_LEN'(1);
    else if (tick && !ring[TAP]) ring <= ring << 1;
  end

  always_ff @(posedge clk) begin
    if (rst)             bit_q <= 1'b0;
    else if (edge_pulse) bit_q <= ring[TAP];
  end

  logic            chk_prev;
  logic [DW:0]     chk_gap;
  always_ff @(posedge clk) begin
    if (rst) begin
      chk_prev <= 1'b0;
      chk_gap  <= '0;
    end else begin
      chk_prev <= carrier_out;
      chk_gap  <= (carrier_out != chk_prev) ? (DW+1)'(1) : chk_gap + 1'b1;
    end
  end

  // R1
  carrier_half_chk: assert property (@(posedge clk) disable iff (rst)
    (carrier_out != chk_prev) |-> (chk_gap == (DW+1)'(DIV_HALF)));

  // R2
  pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
    edge_pulse |=> !edge_pulse);

  // R5
  data_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !edge_pulse |=> $stable(data_out));

  // R3
  data_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(data_out) |-> $past(ring[TAP]));

  // R6
  ring_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(ring) == 1);

  // R7
  ring_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ring[TAP] && !edge_pulse) |=> ring[TAP]);
endmodule

// File: tb/fsk_period_demod_test.sv
module fsk_period_demod_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic comp_in = 1'b0;
  logic carrier_out, edge_pulse, data_out;

  int n_cmp = 0;
  int n_bad = 0;
  int pulses = 0;
  bit reported = 0;

  always #2 clk = ~clk;

  fsk_period_demod uut (
    .clk(clk), .rst(rst), .comp_in(comp_in),
    .carrier_out(carrier_out), .edge_pulse(edge_pulse), .data_out(data_out)
  );

  always @(posedge clk) if (!rst && edge_pulse) pulses <= pulses + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!reported) begin
      reported = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    end
  endtask

  task automatic test_reset();
    repeat (4) @(negedge clk);
    check(carrier_out == 0, "R6 carrier", carrier_out, 0);
    check(edge_pulse == 0, "R6 pulse", edge_pulse, 0);
    check(data_out == 0, "R6 data", data_out, 0);
    rst = 1'b0;
  endtask

  task automatic test_carrier();
    int n = 0;
    logic lvl;
    repeat (63) begin
      @(negedge clk);
      if (carrier_out != 0) n++;
    end
    check(n == 0, "R1 low after reset", n, 0);
    @(negedge clk);
    check(carrier_out == 1, "R1 first toggle", carrier_out, 1);
    for (int k = 0; k < 3; k++) begin
      lvl = carrier_out;
      n = 0;
      while (carrier_out == lvl && n < 200) begin
        @(negedge clk);
        n++;
      end
      check(n == 64, "R1 half period", n, 64);
    end
  endtask

  task automatic test_idle();
    int p0 = pulses;
    repeat (3000) @(negedge clk);
    check(data_out == 0, "R5 idle hold", data_out, 0);
    check(pulses == p0, "R5 idle no pulse", pulses - p0, 0);
  endtask

  task automatic test_pulse_timing();
    int hi_at = -1;
    comp_in = 1'b1;
    for (int c = 1; c <= 4; c++) begin
      @(negedge clk);
      if (edge_pulse && hi_at < 0) hi_at = c;
    end
    check(hi_at == 2, "R2 pulse timing", hi_at, 2);
    check(data_out == 1, "R7 idle gap decodes 1", data_out, 1);
    repeat (700) @(negedge clk);
    comp_in = 1'b0;
    repeat (704) @(negedge clk);
  endtask

  task automatic one_period(input int ncar, input logic exp_bit, input string req);
    int p0 = pulses;
    comp_in = 1'b1;
    repeat (8) @(negedge clk);
    check(data_out == exp_bit, req, data_out, exp_bit);
    repeat (ncar * 64 - 8) @(negedge clk);
    comp_in = 1'b0;
    repeat (ncar * 64 - 1) @(negedge clk);
    check(data_out == exp_bit, "R5 held through gap", data_out, exp_bit);
    check(pulses - p0 == 1, "R2 one pulse per rise", pulses - p0, 1);
    @(negedge clk);
  endtask

  int lens[10] = '{10, 8, 8, 10, 8, 10, 14, 5, 10, 8};

  initial begin
    int prev = 0;
    test_reset();
    test_carrier();
    test_idle();
    test_pulse_timing();
    prev = 10;
    for (int i = 0; i < 10; i++) begin
      if (prev > 10)      one_period(lens[i], 1'b1, "R7 long gap is 1");
      else if (prev == 10) one_period(lens[i], 1'b1, "R3 ten periods is 1");
      else                 one_period(lens[i], 1'b0, "R4 short gap is 0");
      prev = lens[i];
    end
    comp_in = 1'b1;
    repeat (8) @(negedge clk);
    check(data_out == 0, "R4 last eight periods is 0", data_out, 0);
    summary();
    $finish;
  end

  initial begin
    #(200000 * 4);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    summary();
    $finish;
  end
endmodule